// File: doc/BRIEF.md
# Clock Root Control Register Bank

This block is the software-facing control front end of a clock root generator. Through a small register port, software programs a configuration word (source select, half-integer divider, counter mode) and three counter values (M, N, D). Every one of these writes lands in a shadow copy. The clock datapath sees only the active copies, and these change together when software raises the update request in the command register. Hardware clears that request once the shadow contents have been copied across.

The command register also holds three other things. The first is a root force-enable that keeps the root clock running whatever downstream logic asks for. The second is a read-only root-off status. The third is a set of per-register flags that show which shadow registers hold a value that is not yet active.

The request port is valid/ready. A request transfers on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low only for a write while an update is being applied, and reads are always accepted. Read data returns on `rsp_valid_o` exactly one cycle after the read transfers. The response path has no back-pressure.

Top module: `clkroot_regbank`

## Requirements
- R1: A write to the configuration, M, N or D register changes only its shadow copy. The datapath outputs keep their values until an update completes.
- R2: Writing the command register (address 0) with bit 0 set starts an update. Bit 0 reads 1 while the update is pending. `req_ready_o` is low for writes during the UPD_LAT cycles after the transfer. On the last of those cycles all active copies load from the shadows and bit 0 clears. A command write with bit 0 clear starts no update.
- R3: Command bits 4, 5, 6 and 7 read 1 exactly when the shadow differs from the active copy for configuration, N, M and D respectively. Writing back the active value leaves the flag clear.
- R4: All four dirty flags read 0 once an update has completed.
- R5: Command bit 1 is a root force-enable. The root runs when this bit or `clk_req_i` is high. One cycle later, command bit 31 (root-off) reads 0 and `root_on_o` is 1 while the root runs; otherwise bit 31 reads 1 and `root_on_o` is 0.
- R6: Bit 31 and all other command bits except 0 and 1 ignore writes.
- R7: The configuration register (address 1) holds the divider in bits HID_W-1:0, the source select in bits 10:8 and the mode in bits 13:12. Every other bit reads 0. Mode value 2 drives `dual_edge_o` high, and any other mode value drives it low.
- R8: N (address 2), M (address 3) and D (address 4) keep only their low MND_W bits, and their higher bits read 0.
- R9: After reset the source select, divider, mode and M/N/D are 0. Force-enable is 1, so the root runs. The command register reads 0x00000002.
- R10: Each accepted read gives `rsp_valid_o` one cycle later with the shadow value. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| clk_req_i | input | 1 | Downstream request for the root clock |
| root_on_o | output | 1 | Root clock running |
| src_sel_o | output | 3 | Active source select |
| div_o | output | HID_W | Active half-integer divider |
| mode_o | output | 2 | Active counter mode |
| dual_edge_o | output | 1 | Active mode is dual-edge |
| m_o | output | MND_W | Active M value |
| n_o | output | MND_W | Active N value |
| d_o | output | MND_W | Active D value |

## Verification
The configuration register is written with junk in its reserved bits. This separates field masking from field placement. M, N and D are written with values wider than MND_W, which shows whether truncation happens.

Dirty flags are read after a differing write, after a write-back of the active value, and after an update. These reads tell a true compare apart from a sticky write flag. The update is timed by counting stalled write cycles. A command read during the update shows the pending bit, and the outputs are sampled mid-update, which exposes an early copy.

Root status is driven in turn by force-enable alone, by the downstream request alone, and with neither. Unmapped addresses are both read and written.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int NBANK  = 4;

  localparam logic [ADDR_W-1:0] ADDR_CMD = 3'd0;

  // command word bit positions
  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_FORCE_BIT = 1;
  localparam int CMD_DIRTY_LSB = 4;
  localparam int CMD_OFF_BIT   = 31;

  // configuration word layout
  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;
  localparam logic [1:0] MODE_DUAL = 2'd2;

  // bank order matches the dirty flag order; address = index + 1
  typedef enum logic [1:0] {
    BANK_CFG = 2'd0,
    BANK_N   = 2'd1,
    BANK_M   = 2'd2,
    BANK_D   = 2'd3
  } bank_idx_e;

  function automatic logic [DATA_W-1:0] cfg_mask(input int hid_w);
    logic [DATA_W-1:0] m;
    m = DATA_W'((64'd1 << hid_w) - 64'd1);
    m = m | (DATA_W'(3'b111) << CFG_SRC_LSB) | (DATA_W'(2'b11) << CFG_MODE_LSB);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] cnt_mask(input int mnd_w);
    return DATA_W'((64'd1 << mnd_w) - 64'd1);
  endfunction
endpackage

// File: rtl/clkroot_reg_pair.sv
module clkroot_reg_pair #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             apply_i,
  output logic [WIDTH-1:0] shadow_o,
  output logic [WIDTH-1:0] active_o,
  output logic             dirty_o
);
  logic [WIDTH-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en_i) shadow_q <= wr_data_i & MASK;
      if (apply_i) active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
  assign dirty_o  = (shadow_q != active_q);

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(active_q)); // R1
  AST_APPLY_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> active_q == $past(shadow_q)); // R2
endmodule

// File: rtl/clkroot_update_ctl.sv
module clkroot_update_ctl #(
  parameter int LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic apply_o
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign apply_o = busy_q && (cnt_q == LAST);
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (apply_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_UPD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_o |=> !busy_o); // R2
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R2
endmodule

// File: rtl/clkroot_root_ctl.sv
module clkroot_root_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_wr_i,
  input  logic force_val_i,
  input  logic clk_req_i,
  output logic force_o,
  output logic root_off_o
);
  logic force_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_q <= 1'b1;
      off_q   <= 1'b0;
    end else begin
      if (force_wr_i) force_q <= force_val_i;
      off_q <= !(force_q || clk_req_i);
    end
  end

  assign force_o    = force_q;
  assign root_off_o = off_q;

  AST_ROOT_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_q || clk_req_i) |=> !root_off_o); // R5
  AST_ROOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(force_q || clk_req_i) |=> root_off_o); // R5
endmodule

// File: rtl/clkroot_bus_front.sv
module clkroot_bus_front
  import clkroot_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic                         req_write_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic                         busy_i,
  input  logic [DATA_W-1:0]            cmd_rd_i,
  input  logic [NBANK-1:0][DATA_W-1:0] bank_rd_i,
  output logic                         req_ready_o,
  output logic                         cmd_wr_o,
  output logic [NBANK-1:0]             bank_wr_o,
  output logic                         rsp_valid_o,
  output logic [DATA_W-1:0]            rsp_rdata_o
);
  logic              fire, rd_fire;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready_o = !(busy_i && req_write_i);
  assign fire        = req_valid_i && req_ready_o;
  assign rd_fire     = fire && !req_write_i;
  assign cmd_wr_o    = fire && req_write_i && (req_addr_i == ADDR_CMD);

  for (genvar i = 0; i < NBANK; i++) begin : g_dec
    assign bank_wr_o[i] = fire && req_write_i && (req_addr_i == ADDR_W'(i + 1));
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr_i == ADDR_CMD) rd_mux = cmd_rd_i;
    for (int i = 0; i < NBANK; i++) begin
      if (req_addr_i == ADDR_W'(i + 1)) rd_mux = bank_rd_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_fire;
      if (rd_fire) rsp_rdata_o <= rd_mux;
    end
  end

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_write_i) |=> rsp_valid_o); // R10
  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (bank_wr_o == '0) && !cmd_wr_o); // R2
endmodule

// File: rtl/clkroot_regbank.sv
module clkroot_regbank
  import clkroot_pkg::*;
#(
  parameter int HID_W   = 5,
  parameter int MND_W   = 8,
  parameter int UPD_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              clk_req_i,
  output logic              root_on_o,
  output logic [2:0]        src_sel_o,
  output logic [HID_W-1:0]  div_o,
  output logic [1:0]        mode_o,
  output logic              dual_edge_o,
  output logic [MND_W-1:0]  m_o,
  output logic [MND_W-1:0]  n_o,
  output logic [MND_W-1:0]  d_o
);
  localparam logic [DATA_W-1:0] CFG_MASK = cfg_mask(HID_W);
  localparam logic [DATA_W-1:0] CNT_MASK = cnt_mask(MND_W);

  logic                         cmd_wr, busy, apply, force_en, root_off;
  logic [NBANK-1:0]             bank_wr, dirty;
  logic [NBANK-1:0][DATA_W-1:0] shadow, active;
  logic [DATA_W-1:0]            cmd_rd;

  clkroot_bus_front u_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .busy_i      (busy),
    .cmd_rd_i    (cmd_rd),
    .bank_rd_i   (shadow),
    .req_ready_o (req_ready_o),
    .cmd_wr_o    (cmd_wr),
    .bank_wr_o   (bank_wr),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  clkroot_update_ctl #(.LAT(UPD_LAT)) u_upd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_wr && req_wdata_i[CMD_UPD_BIT]),
    .busy_o  (busy),
    .apply_o (apply)
  );

  clkroot_root_ctl u_root (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_wr_i  (cmd_wr),
    .force_val_i (req_wdata_i[CMD_FORCE_BIT]),
    .clk_req_i   (clk_req_i),
    .force_o     (force_en),
    .root_off_o  (root_off)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [DATA_W-1:0] MASK = (i == int'(BANK_CFG)) ? CFG_MASK : CNT_MASK;
    clkroot_reg_pair #(.WIDTH(DATA_W), .MASK(MASK)) u_pair (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bank_wr[i]),
      .wr_data_i (req_wdata_i),
      .apply_i   (apply),
      .shadow_o  (shadow[i]),
      .active_o  (active[i]),
      .dirty_o   (dirty[i])
    );
  end

  assign cmd_rd = {root_off, 23'd0, dirty, 2'd0, force_en, busy};

  assign root_on_o   = !root_off;
  assign div_o       = active[BANK_CFG][HID_W-1:0];
  assign src_sel_o   = active[BANK_CFG][CFG_SRC_LSB +: 3];
  assign mode_o      = active[BANK_CFG][CFG_MODE_LSB +: 2];
  assign dual_edge_o = (mode_o == MODE_DUAL);
  assign n_o         = active[BANK_N][MND_W-1:0];
  assign m_o         = active[BANK_M][MND_W-1:0];
  assign d_o         = active[BANK_D][MND_W-1:0];

  logic unused_active_bits;
  assign unused_active_bits = ^active;

  AST_DIRTY_CLEAR_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (dirty == '0)); // R4
  AST_OUTPUTS_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(src_sel_o) && $stable(div_o) && $stable(m_o)); // R1
endmodule

// File: tb/clkroot_regbank_bench.sv
module clkroot_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, clk_req = 1'b0;
  logic [31:0] rsp_rdata;
  logic        root_on, dual_edge;
  logic [2:0]  src_sel;
  logic [4:0]  div;
  logic [1:0]  mode;
  logic [7:0]  m, n, d;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  clkroot_regbank u_clkroot_regbank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .clk_req_i(clk_req), .root_on_o(root_on),
    .src_sel_o(src_sel), .div_o(div), .mode_o(mode), .dual_edge_o(dual_edge),
    .m_o(m), .n_o(n), .d_o(d)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_wr(logic [2:0] a, logic [31:0] dat);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = dat;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    req_write = 1'b1; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_write = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 src", {29'd0, src_sel}, 0);
    chk("R9 div", {27'd0, div}, 0);
    chk("R9 mnd", {8'd0, m, n, d}, 0);
    chk("R9 root_on", {31'd0, root_on}, 1);
    bus_rd(3'd0, 32'h0000_0002, "R9 cmd reset");

    // R7 cfg with junk in reserved bits, R1 outputs unchanged
    bus_wr(3'd1, 32'hABCD_2B25);
    bus_rd(3'd1, 32'h0000_2305, "R7 cfg masked readback");
    chk("R1 src before update", {29'd0, src_sel}, 0);
    bus_rd(3'd0, 32'h0000_0012, "R3 cfg dirty");

    // R8 masking of counters: N addr2, M addr3, D addr4
    bus_wr(3'd2, 32'hFFFF_FF0F);
    bus_wr(3'd3, 32'h0000_0123);
    bus_wr(3'd4, 32'h0000_01C4);
    bus_rd(3'd2, 32'h0000_000F, "R8 N masked");
    bus_rd(3'd3, 32'h0000_0023, "R8 M masked");
    bus_rd(3'd4, 32'h0000_00C4, "R8 D masked");
    bus_rd(3'd0, 32'h0000_00F2, "R3 all dirty");
    chk("R1 m before update", {24'd0, m}, 0);

    // R2/R6 update with attempt to set bit31
    bus_wr(3'd0, 32'h8000_0003);
    bus_rd(3'd0, 32'h0000_00F3, "R2 pending bit visible, R6 bit31 ignored");
    chk("R1 src mid-update", {29'd0, src_sel}, 0);
    wait_idle();
    chk("R2 src applied", {29'd0, src_sel}, 3);
    chk("R2 div applied", {27'd0, div}, 5);
    chk("R7 mode applied", {30'd0, mode}, 2);
    chk("R7 dual edge on", {31'd0, dual_edge}, 1);
    chk("R2 mnd applied", {8'd0, m, n, d}, {8'd0, 8'h23, 8'h0F, 8'hC4});
    bus_rd(3'd0, 32'h0000_0002, "R4 dirty cleared after update");

    // R2 exact latency, R7 mode 1
    bus_wr(3'd1, 32'h0000_171F);
    bus_wr(3'd0, 32'h0000_0003);
    cyc = 0;
    #1;
    while (!req_ready) begin cyc++; @(negedge clk); #1; end
    req_write = 1'b0;
    chk("R2 update latency", cyc, 3);
    chk("R7 src 7", {29'd0, src_sel}, 7);
    chk("R7 div max", {27'd0, div}, 32'h1F);
    chk("R7 dual edge off", {31'd0, dual_edge}, 0);

    // R2 command write without update bit
    bus_wr(3'd0, 32'h0000_0002);
    req_write = 1'b1; #1;
    chk("R2 no update started", {31'd0, req_ready}, 1);
    req_write = 1'b0;

    // R5 root status
    bus_wr(3'd0, 32'h0000_0000);
    @(negedge clk);
    chk("R5 root off", {31'd0, root_on}, 0);
    bus_rd(3'd0, 32'h8000_0000, "R5 root-off bit set");
    clk_req = 1'b1;
    @(negedge clk);
    chk("R5 request runs root", {31'd0, root_on}, 1);
    bus_rd(3'd0, 32'h0000_0000, "R5 root-off clear by request");
    clk_req = 1'b0;
    bus_wr(3'd0, 32'h0000_0002);
    @(negedge clk);
    chk("R5 force runs root", {31'd0, root_on}, 1);

    // R3 compare semantics
    bus_wr(3'd3, 32'h0000_0123);
    bus_wr(3'd2, 32'h0000_0055);
    bus_rd(3'd0, 32'h0000_0022, "R3 only N dirty");
    bus_wr(3'd2, 32'h0000_000F);
    bus_rd(3'd0, 32'h0000_0002, "R3 write-back clears flag");

    // R10 unmapped addresses
    bus_wr(3'd7, 32'hFFFF_FFFF);
    bus_rd(3'd7, 32'h0, "R10 addr7 reads 0");
    bus_rd(3'd5, 32'h0, "R10 addr5 reads 0");
    bus_rd(3'd0, 32'h0000_0002, "R10 unmapped write no effect");
    chk("R10 outputs unchanged", {8'd0, m, n, d}, {8'd0, 8'h23, 8'h0F, 8'hC4});

    repeat (3) @(negedge clk);
    chk("R10 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule